// File: doc/BRIEF.md
# Atomic-Launch Message Network Interface

This block sits between a processor's register bus and one network port. Software builds an outgoing message by writing words into a small bank of staging registers and a length register. Nothing leaves the block at that point. The whole message is pushed into the output queue only when a launch command is written. Because nothing is sent before the launch, a message that is half built can be read out, saved, restored or thrown away without leaving a partial packet in the network.

Arriving flits go into an input queue. A loader moves one complete message at a time into a receive window that software can read. While a message sits in the window, the block can raise an interrupt, or software can poll a status bit. Software frees the window with a dispose command. Later messages wait in the input queue, and when that queue is full the network is held off.

Top module: `msg_nic`

## Requirements
- R1: After reset, tx_valid, irq and reg_stall are 0, rx_ready is 1, and the status register (address 18) reads 0.
- R2: Staging words at addresses 0..7 and the length register at address 16 (flit count minus one, bits [2:0]) read back the value last written. Every register read returns data one cycle after the address is presented.
- R3: Writing staging words or the length register never makes tx_valid rise. A flit appears only after a launch.
- R4: Writing 1 to bit 0 of the command register (address 17) emits flits from staging words 0..len-1 in index order. The first flit has tx_head set and the last has tx_tail set; a one-flit message has both set.
- R5: If the output queue has fewer free entries than the message length, the launch sends nothing and sets status bit 0 (busy). A later accepted launch clears that bit.
- R6: After an accepted launch, reg_stall is high for exactly len cycles. A register write presented in that time waits, and it does not alter the flits being launched.
- R7: When a tail flit has been loaded, status bit 2 (message present) is 1 and status bits [6:4] hold the received flit count minus one. Receive words are at addresses 8..15.
- R8: irq is 1 exactly when a message is present and control bit 0 (address 19) is 1. With that bit at 0, irq stays 0 and the message is still visible in the status register.
- R9: Writing 1 to command bit 1 (dispose) with a message present clears present, and the next queued message loads into the window.
- R10: A dispose with no message present sets sticky status bit 1 and changes nothing else. Writing 1 to status bit 1 clears it.
- R11: While a message is present, later arrivals wait in the input queue, and rx_ready drops to 0 once that queue is full.
- R12: The room check for a launch uses the queue occupancy in the command's own cycle. A flit drained in that same cycle does not count toward the room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 5 | Register address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after reg_addr |
| reg_stall | output | 1 | Write held off while a launch is streaming |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Network accepts the outgoing flit |
| tx_data | output | 32 | Outgoing flit payload |
| tx_head | output | 1 | Outgoing flit is the first of its message |
| tx_tail | output | 1 | Outgoing flit is the last of its message |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Input queue can take a flit |
| rx_data | input | 32 | Incoming flit payload |
| rx_head | input | 1 | Incoming flit starts a message |
| rx_tail | input | 1 | Incoming flit ends a message |
| irq | output | 1 | Message-present interrupt |

## Verification
The critical coincidence is a launch command arriving in the same cycle as the network drains a flit from a full output queue. The bench fills the queue with tx_ready held low, leaves busy set by one rejected launch, and then at one clock edge raises tx_ready and writes the launch command together. The launch must be judged against the queue as it was in that cycle. So reg_stall must stay low, busy must remain set, and exactly the sixteen queued flits may come out. A second coincidence is a staging write presented while a launch is still streaming. The bench checks that the launched flits carry the old word and that the staging register later reads back the new one.

// File: rtl/msg_nic_pkg.sv
package msg_nic_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SEND_BASE = 5'd0;
  localparam logic [ADDR_W-1:0] A_RECV_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] A_LEN       = 5'd16;
  localparam logic [ADDR_W-1:0] A_CMD       = 5'd17;
  localparam logic [ADDR_W-1:0] A_STAT      = 5'd18;
  localparam logic [ADDR_W-1:0] A_CTRL      = 5'd19;

  localparam int CMD_LAUNCH  = 0;
  localparam int CMD_DISPOSE = 1;

  localparam int ST_BUSY    = 0;
  localparam int ST_DERR    = 1;
  localparam int ST_PRESENT = 2;
  localparam int ST_LEN_LSB = 4;

  localparam int CTRL_IRQ_EN = 0;
endpackage

// File: rtl/nic_fifo.sv
module nic_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign count = cnt;
  assign empty = (cnt == '0);
endmodule

// File: rtl/nic_tx_stage.sv
module nic_tx_stage #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 8,
  parameter int OF_DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(MAX_WORDS)-1:0]  wr_idx,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          len_we,
  input  logic [$clog2(MAX_WORDS)-1:0]  len_in,
  input  logic                          launch_req,
  input  logic [$clog2(OF_DEPTH+1)-1:0] of_count,
  input  logic [$clog2(MAX_WORDS)-1:0]  rd_idx,
  output logic [DW-1:0]                 rd_word,
  output logic [$clog2(MAX_WORDS)-1:0]  len_m1,
  output logic                          busy,
  output logic                          sending,
  output logic                          push,
  output logic [DW+1:0]                 push_flit
);
  localparam int WIDX_W = $clog2(MAX_WORDS);
  localparam int CNT_W  = $clog2(OF_DEPTH+1);

  logic [DW-1:0]     words [MAX_WORDS];
  logic [WIDX_W-1:0] len_q, idx_q;
  logic              busy_q, send_q;
  logic [CNT_W:0]    room, need;
  logic              fits;

  assign room = (CNT_W+1)'(OF_DEPTH) - {1'b0, of_count};
  assign need = (CNT_W+1)'(len_q) + (CNT_W+1)'(1);
  assign fits = (room >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_WORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      send_q <= 1'b0;
    end else begin
      if (len_we) len_q <= len_in;
      if (send_q) begin
        if (idx_q == len_q) send_q <= 1'b0;
        else                idx_q  <= idx_q + WIDX_W'(1);
      end else if (launch_req) begin
        if (fits) begin
          send_q <= 1'b1;
          idx_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign push      = send_q;
  assign push_flit = {idx_q == '0, idx_q == len_q, words[idx_q]};
  assign rd_word   = words[rd_idx];
  assign len_m1    = len_q;
  assign busy      = busy_q;
  assign sending   = send_q;
endmodule

// File: rtl/nic_rx_window.sv
module nic_rx_window #(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_avail,
  input  logic [DW+1:0]                in_flit,
  output logic                         in_pop,
  input  logic                         dispose_req,
  input  logic                         clr_err,
  input  logic [$clog2(MAX_WORDS)-1:0] rd_idx,
  output logic [DW-1:0]                rd_word,
  output logic                         present,
  output logic [$clog2(MAX_WORDS)-1:0] len_m1,
  output logic                         derr
);
  localparam int WIDX_W = $clog2(MAX_WORDS);
  localparam int FILL_W = WIDX_W + 1;

  logic [DW-1:0]     win [MAX_WORDS];
  logic [FILL_W-1:0] fill, pos;
  logic              pres_q, derr_q;
  logic [WIDX_W-1:0] len_q;
  logic              f_head, f_tail;
  logic [DW-1:0]     f_data;

  assign {f_head, f_tail, f_data} = in_flit;
  assign in_pop = in_avail && !pres_q;
  assign pos    = f_head ? '0 : fill;

  always_ff @(posedge clk) begin
    if (in_pop && (pos < FILL_W'(MAX_WORDS))) win[pos[WIDX_W-1:0]] <= f_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill   <= '0;
      pres_q <= 1'b0;
      derr_q <= 1'b0;
      len_q  <= '0;
    end else begin
      if (in_pop) begin
        if (f_tail) begin
          pres_q <= 1'b1;
          fill   <= '0;
          len_q  <= (pos >= FILL_W'(MAX_WORDS)) ? WIDX_W'(MAX_WORDS-1) : pos[WIDX_W-1:0];
        end else begin
          fill <= (pos == FILL_W'(MAX_WORDS)) ? pos : pos + FILL_W'(1);
        end
      end
      if (dispose_req) begin
        if (pres_q) pres_q <= 1'b0;
        else        derr_q <= 1'b1;
      end else if (clr_err) begin
        derr_q <= 1'b0;
      end
    end
  end

  assign rd_word = win[rd_idx];
  assign present = pres_q;
  assign len_m1  = len_q;
  assign derr    = derr_q;
endmodule

// File: rtl/msg_nic.sv
module msg_nic
  import msg_nic_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MAX_WORDS = 8,
  parameter int OF_DEPTH  = 16,
  parameter int IF_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_stall,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_head,
  output logic              tx_tail,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_head,
  input  logic              rx_tail,
  output logic              irq
);
  localparam int WIDX_W = $clog2(MAX_WORDS);
  localparam int OCW    = $clog2(OF_DEPTH+1);
  localparam int ICW    = $clog2(IF_DEPTH+1);
  localparam int FW     = DW + 2;

  logic              wr_ok, send_we, len_we, launch_req, dispose_req, clr_err;
  logic [WIDX_W-1:0] idx;
  logic [DW-1:0]     tx_word, rx_word, rd_next;
  logic [WIDX_W-1:0] tx_len, rx_len;
  logic              tx_busy, tx_sending, of_push, of_empty;
  logic [FW-1:0]     of_in, of_out, if_out;
  logic [OCW-1:0]    of_count;
  logic [ICW-1:0]    if_count;
  logic              if_empty, if_pop, if_push;
  logic              rx_present, rx_derr;
  logic              irq_en_q, irq_q;
  logic [DW-1:0]     rdata_q;

  assign wr_ok       = reg_wr && !tx_sending;
  assign idx         = reg_addr[WIDX_W-1:0];
  assign send_we     = wr_ok && (reg_addr < A_RECV_BASE);
  assign len_we      = wr_ok && (reg_addr == A_LEN);
  assign launch_req  = wr_ok && (reg_addr == A_CMD) && reg_wdata[CMD_LAUNCH];
  assign dispose_req = wr_ok && (reg_addr == A_CMD) && reg_wdata[CMD_DISPOSE];
  assign clr_err     = wr_ok && (reg_addr == A_STAT) && reg_wdata[ST_DERR];

  nic_tx_stage #(.DW(DW), .MAX_WORDS(MAX_WORDS), .OF_DEPTH(OF_DEPTH)) tx_stage_i (
    .clk(clk), .rst(rst),
    .wr_en(send_we), .wr_idx(idx), .wr_data(reg_wdata),
    .len_we(len_we), .len_in(reg_wdata[WIDX_W-1:0]),
    .launch_req(launch_req), .of_count(of_count),
    .rd_idx(idx), .rd_word(tx_word),
    .len_m1(tx_len), .busy(tx_busy), .sending(tx_sending),
    .push(of_push), .push_flit(of_in)
  );

  nic_fifo #(.W(FW), .DEPTH(OF_DEPTH)) out_q_i (
    .clk(clk), .rst(rst),
    .push(of_push), .din(of_in),
    .pop(tx_ready), .dout(of_out),
    .count(of_count), .empty(of_empty)
  );

  assign tx_valid = !of_empty;
  assign {tx_head, tx_tail, tx_data} = of_out;

  assign rx_ready = (if_count != ICW'(IF_DEPTH));
  assign if_push  = rx_valid && rx_ready;

  nic_fifo #(.W(FW), .DEPTH(IF_DEPTH)) in_q_i (
    .clk(clk), .rst(rst),
    .push(if_push), .din({rx_head, rx_tail, rx_data}),
    .pop(if_pop), .dout(if_out),
    .count(if_count), .empty(if_empty)
  );

  nic_rx_window #(.DW(DW), .MAX_WORDS(MAX_WORDS)) rx_win_i (
    .clk(clk), .rst(rst),
    .in_avail(!if_empty), .in_flit(if_out), .in_pop(if_pop),
    .dispose_req(dispose_req), .clr_err(clr_err),
    .rd_idx(idx), .rd_word(rx_word),
    .present(rx_present), .len_m1(rx_len), .derr(rx_derr)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr < A_RECV_BASE) begin
      rd_next = tx_word;
    end else if (reg_addr < A_LEN) begin
      rd_next = rx_word;
    end else begin
      case (reg_addr)
        A_LEN:  rd_next[WIDX_W-1:0] = tx_len;
        A_STAT: begin
          rd_next[ST_BUSY]                  = tx_busy;
          rd_next[ST_DERR]                  = rx_derr;
          rd_next[ST_PRESENT]               = rx_present;
          rd_next[ST_LEN_LSB +: WIDX_W]     = rx_len;
        end
        A_CTRL: rd_next[CTRL_IRQ_EN] = irq_en_q;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rdata_q <= rd_next;
      if (wr_ok && (reg_addr == A_CTRL)) irq_en_q <= reg_wdata[CTRL_IRQ_EN];
      irq_q <= rx_present && irq_en_q;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_stall = tx_sending;
  assign irq       = irq_q;
endmodule

// File: rtl/nic_sva.sv
module nic_sva #(
  parameter int MAX_WORDS = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tx_valid,
  input logic                         irq,
  input logic                         reg_stall,
  input logic                         rx_present,
  input logic [$clog2(MAX_WORDS)-1:0] rx_len,
  input logic                         busy,
  input logic                         derr,
  input logic                         dispose_req,
  input logic                         clr_err
);
  logic [7:0] stall_run;

  always_ff @(posedge clk) begin
    if (rst)                                  stall_run <= '0;
    else if (reg_stall && stall_run != 8'hff) stall_run <= stall_run + 8'd1;
    else if (!reg_stall)                      stall_run <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && !irq && !reg_stall));

  p_no_early_flit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(reg_stall));

  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !reg_stall);

  p_stall_bound_r6: assert property (@(posedge clk) disable iff (rst)
    stall_run <= 8'(MAX_WORDS));

  p_window_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_present && !dispose_req) |=> (rx_present && $stable(rx_len)));

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_present) |=> !irq);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (derr && !clr_err) |=> derr);
endmodule

bind msg_nic nic_sva #(.MAX_WORDS(MAX_WORDS)) sva_i (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .irq(irq),
  .reg_stall(reg_stall), .rx_present(rx_present), .rx_len(rx_len),
  .busy(tx_busy), .derr(rx_derr), .dispose_req(dispose_req), .clr_err(clr_err)
);

// File: tb/msg_nic_tb_top.sv
module msg_nic_tb_top;
  localparam logic [4:0] AL = 5'd16, AC = 5'd17, AS = 5'd18, ACT = 5'd19;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_stall, tx_valid, tx_ready = 1'b0, tx_head, tx_tail;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready, rx_head = 1'b0, rx_tail = 1'b0, irq;
  logic [31:0] rx_data = '0;

  int tests = 0, fails = 0, ncap = 0;
  logic [31:0] cap_d [512];
  logic        cap_h [512];
  logic        cap_t [512];
  logic [31:0] stage [8];
  logic [31:0] rxm [3][8];

  always #10 clk = ~clk;

  msg_nic dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_stall(reg_stall), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_head(tx_head), .tx_tail(tx_tail), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_head(rx_head), .rx_tail(rx_tail), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst && tx_valid && tx_ready && ncap < 512) begin
      cap_d[ncap] <= tx_data;
      cap_h[ncap] <= tx_head;
      cap_t[ncap] <= tx_tail;
      ncap <= ncap + 1;
    end
  end

  function automatic logic [31:0] stat_exp(input logic busy, derr, pres, input int lm1);
    logic [31:0] v = '0;
    v[0] = busy; v[1] = derr; v[2] = pres; v[6:4] = 3'(lm1);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #1;
    while (reg_stall) begin @(negedge clk); #1; end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic launch(output int stall_cycles);
    wr(AC, 32'h1);
    stall_cycles = 0;
    while (reg_stall) begin stall_cycles++; @(negedge clk); end
  endtask

  task automatic send_rx(input int m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = rxm[m][i]; rx_head = (i == 0); rx_tail = (i == n-1);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_head = 1'b0; rx_tail = 1'b0;
  endtask

  task automatic check_flits(input string req, input int base, input int n);
    for (int i = 0; i < n; i++) begin
      check(req, cap_d[base+i], stage[i]);
      check(req, {30'd0, cap_h[base+i], cap_t[base+i]}, {30'd0, i == 0, i == n-1});
    end
  endtask

  task automatic do_tx(input string req, input int n);
    int base, sc;
    base = ncap;
    for (int i = 0; i < n; i++) wr(5'(i), stage[i]);
    wr(AL, 32'(n-1));
    launch(sc);
    check("R6 stall length", 32'(sc), 32'(n));
    repeat (n + 6) @(negedge clk);
    check(req, 32'(ncap - base), 32'(n));
    check_flits(req, base, n);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int sc, base, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    check("R1 stall", {31'd0, reg_stall}, 32'd0);
    rd(AS, v); check("R1 status", v, 32'd0);

    // R10 dispose with nothing present
    wr(AC, 32'h2);
    rd(AS, v); check("R10 sticky error", v, stat_exp(0, 1, 0, 0));
    check("R10 rx_ready untouched", {31'd0, rx_ready}, 32'd1);
    wr(AS, 32'h2);
    rd(AS, v); check("R10 clear", v, 32'd0);

    // R2 readback, R3 no flit before launch
    tx_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin stage[i] = $urandom; wr(5'(i), stage[i]); end
    wr(AL, 32'd5);
    for (int i = 0; i < 8; i++) begin rd(5'(i), v); check("R2 staging readback", v, stage[i]); end
    rd(AL, v); check("R2 length readback", v, 32'd5);
    repeat (5) @(negedge clk);
    check("R3 nothing sent before launch", 32'(ncap), 32'd0);

    // R4 directed edge lengths
    do_tx("R4 single flit", 1);
    do_tx("R4 full message", 8);

    // R6 write during launch waits and does not alter flits
    for (int i = 0; i < 4; i++) stage[i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 4; i++) wr(5'(i), stage[i]);
    wr(AL, 32'd3);
    base = ncap;
    wr(AC, 32'h1);
    wr(5'd3, 32'hBEEF_0003);
    repeat (10) @(negedge clk);
    check_flits("R6 launch unaffected by stalled write", base, 4);
    rd(5'd3, v); check("R6 stalled write lands", v, 32'hBEEF_0003);

    // R4 random messages
    for (int k = 0; k < 12; k++) begin
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) stage[i] = $urandom;
      do_tx("R4 random message", n);
    end

    // R5 / R12 full output queue
    tx_ready = 1'b0;
    base = ncap;
    for (int i = 0; i < 8; i++) begin stage[i] = 32'hC000_0000 + 32'(i); wr(5'(i), stage[i]); end
    wr(AL, 32'd7);
    launch(sc); check("R5 first fill accepted", 32'(sc), 32'd8);
    launch(sc); check("R5 second fill accepted", 32'(sc), 32'd8);
    wr(AL, 32'd0);
    launch(sc); check("R5 rejected sends nothing", 32'(sc), 32'd0);
    rd(AS, v); check("R5 busy set", v, stat_exp(1, 0, 0, 0));
    @(negedge clk);
    tx_ready = 1'b1; reg_addr = AC; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1 check("R12 same-cycle drain not counted", {31'd0, reg_stall}, 32'd0);
    repeat (25) @(negedge clk);
    rd(AS, v); check("R12 busy still set", v, stat_exp(1, 0, 0, 0));
    check("R12 only queued flits", 32'(ncap - base), 32'd16);
    check_flits("R5 queued order", base, 8);
    check_flits("R5 queued order", base + 8, 8);
    launch(sc);
    repeat (5) @(negedge clk);
    rd(AS, v); check("R5 busy cleared by accepted launch", v, 32'd0);
    check("R5 late launch sent", 32'(ncap - base), 32'd17);

    // R7 / R8 receive with interrupt disabled
    for (int m = 0; m < 3; m++) for (int i = 0; i < 8; i++) rxm[m][i] = $urandom;
    send_rx(0, 3);
    repeat (8) @(negedge clk);
    rd(AS, v); check("R7 present and length", v, stat_exp(0, 0, 1, 2));
    for (int i = 0; i < 3; i++) begin rd(5'(8 + i), v); check("R7 window word", v, rxm[0][i]); end
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(ACT, 32'h1);
    repeat (2) @(negedge clk);
    check("R8 irq enabled", {31'd0, irq}, 32'd1);
    wr(ACT, 32'h0);
    repeat (2) @(negedge clk);
    check("R8 irq disabled again", {31'd0, irq}, 32'd0);

    // R11 backpressure, R9 dispose
    send_rx(1, 8);
    send_rx(2, 8);
    repeat (3) @(negedge clk);
    check("R11 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    rd(5'd8, v); check("R11 window keeps first", v, rxm[0][0]);
    wr(AC, 32'h2);
    repeat (15) @(negedge clk);
    rd(AS, v); check("R9 next message loaded", v, stat_exp(0, 0, 1, 7));
    for (int i = 0; i < 8; i++) begin rd(5'(8 + i), v); check("R9 window word", v, rxm[1][i]); end
    check("R11 rx_ready back", {31'd0, rx_ready}, 32'd1);
    wr(AC, 32'h2);
    repeat (15) @(negedge clk);
    rd(5'd15, v); check("R9 third message", v, rxm[2][7]);
    wr(AC, 32'h2);
    repeat (4) @(negedge clk);
    rd(AS, v); check("R9 window empty", v, stat_exp(0, 0, 0, 7));
    wr(AC, 32'h2);
    rd(AS, v); check("R10 dispose on empty", v, stat_exp(0, 1, 0, 7));
    wr(AS, 32'h2);

    // R7 random receives
    for (int k = 0; k < 6; k++) begin
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) rxm[0][i] = $urandom;
      send_rx(0, n);
      repeat (12) @(negedge clk);
      rd(AS, v); check("R7 random status", v, stat_exp(0, 0, 1, n - 1));
      for (int i = 0; i < n; i++) begin rd(5'(8 + i), v); check("R7 random word", v, rxm[0][i]); end
      wr(AC, 32'h2);
    end

    finish_run();
  end
endmodule